// File: doc/BRIEF.md
# Checksum-Gated Burst Write Engine

This block sits between a serial front-end, which has already turned the wire traffic into bytes, and a byte-wide memory write port. A frame is a run of byte-valid strobes followed by an end-of-frame strobe. The first two bytes carry the start address, high byte first. The next 64 bytes carry the payload. The last two bytes carry a CRC-16, high byte first.

The payload is held in a staging buffer while a running checksum is folded over the address and payload bytes. When the frame closes, the engine compares the transmitted checksum with its own. If the two match and the frame had exactly the right length, the engine replays the buffer to memory, one byte per clock at ascending addresses. If anything is wrong, memory is left untouched and a sticky error flag is raised.

Block protection then filters individual writes of an accepted burst. A byte whose address falls in the protected range is simply not written. The checksum verdict is unaffected by protection.

Top module: `crc_burst_writer`

## Requirements
- R1: A frame is committed only when exactly 68 bytes have been accepted before the end-of-frame strobe. Byte 0 is the address high byte, byte 1 the address low byte, bytes 2 to 65 the payload, byte 66 the checksum high byte and byte 67 the checksum low byte.
- R2: A committed frame produces exactly 64 memory writes, unless R7 suppresses some of them. Payload byte k goes to address (start + k) modulo 65536, so a burst may wrap past 0xFFFF to 0x0000.
- R3: The reference checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first over the two address bytes and then the 64 payload bytes. If it differs from the transmitted value, no write is issued and err_flag becomes 1. This holds whether the corruption is in an address byte, a payload byte or a checksum byte.
- R4: A frame that closes with fewer or more than 68 bytes is discarded. No write is issued and err_flag becomes 1.
- R5: The writes of one commit appear in consecutive clock cycles with addresses rising by one.
- R6: err_flag changes only in the cycle after an accepted end-of-frame strobe. A committed frame clears it and a rejected frame sets it.
- R7: prot_sel selects the protected range: 0 means none, 1 means the top quarter (address bits 15:14 both 1), 2 means the top half (bit 15 = 1), and 3 means the whole space. Writes to protected addresses are dropped even when the checksum is valid, and err_flag is still cleared.
- R8: While a commit is being replayed, incoming bytes and end-of-frame strobes are ignored. The next frame after the replay is received from its first byte.
- R9: The end-of-frame strobe may arrive in the same cycle as the final checksum byte, and that byte counts as part of the frame.
- R10: Synchronous reset clears mem_we and err_flag and discards a partly received frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte holds a frame byte this cycle |
| in_byte | input | 8 | Frame byte from the serial front-end |
| in_eof | input | 1 | End-of-frame strobe |
| prot_sel | input | 2 | Protected-range selector (R7) |
| mem_we | output | 1 | Registered memory write enable |
| mem_addr | output | 16 | Registered memory write address |
| mem_wdata | output | 8 | Registered memory write data |
| err_flag | output | 1 | Sticky result of the last closed frame, 1 means rejected |

## Verification
Two pairs of events can land in the same cycle. The first pair is the final checksum byte and the frame-closing strobe. The second pair is a commit replay and the reception of new traffic. The first is provoked by alternating, across an address sweep, between a strobe on its own cycle and a strobe on the last byte; the frame must commit either way. The second is provoked by sending a short junk frame and a strobe straight after a good frame closes. The replayed contents and err_flag must match the good frame, and the frame that follows must commit cleanly.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  // Fold one byte into the running checksum, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ b[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/crcw_crc_acc.sv
module crcw_crc_acc
  import crcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_SEED;
    else if (en)    crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/crcw_stage_buf.sv
module crcw_stage_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/crcw_commit_seq.sv
module crcw_commit_seq #(
  parameter int ADDR_W = 16,
  parameter int BURST  = 64,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        prot_sel,
  input  logic [DW-1:0]     rdata,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] rd_a;
  logic              rd_v;

  function automatic logic in_guard(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    case (s)
      2'd0:    return 1'b0;
      2'd1:    return &a[ADDR_W-1 -: 2];
      2'd2:    return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  // Stage 0: issue index; stage 1: buffer read; stage 2: registered write port.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rd_idx    <= '0;
      base_q    <= '0;
      rd_v      <= 1'b0;
      rd_a      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      if (start) begin
        busy   <= 1'b1;
        rd_idx <= '0;
        base_q <= base;
      end else if (busy) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == IDX_W'(BURST - 1)) busy <= 1'b0;
      end
      rd_v      <= busy;
      rd_a      <= base_q + ADDR_W'(rd_idx);
      mem_we    <= rd_v && !in_guard(rd_a, prot_sel);
      mem_addr  <= rd_a;
      mem_wdata <= rdata;
    end
  end

endmodule

// File: rtl/crc_burst_writer.sv
module crc_burst_writer
  import crcw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BURST  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_eof,
  input  logic [1:0]        prot_sel,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              err_flag
);

  localparam int HDR   = ADDR_W / BYTE_W;
  localparam int TOTAL = HDR + BURST + CRC_W / BYTE_W;
  localparam int CNT_W = $clog2(TOTAL + 2);
  localparam int IDX_W = $clog2(BURST);

  logic [CNT_W-1:0]  rx_cnt, cnt_nxt;
  logic [ADDR_W-1:0] base_q;
  logic [CRC_W-1:0]  rxcrc_q, rxcrc_nxt, crc_q;
  logic              busy;
  logic              accept, eof_acc, frame_ok;
  logic              in_hdr, in_data, in_tail;
  logic [IDX_W-1:0]  rd_idx;
  logic [7:0]        buf_rdata;

  always_comb begin
    accept   = in_valid && !busy;
    eof_acc  = in_eof && !busy;
    in_hdr   = rx_cnt < CNT_W'(HDR);
    in_data  = !in_hdr && (rx_cnt < CNT_W'(HDR + BURST));
    in_tail  = !in_hdr && !in_data && (rx_cnt < CNT_W'(TOTAL));
    cnt_nxt  = (accept && rx_cnt != CNT_W'(TOTAL + 1)) ? rx_cnt + 1'b1 : rx_cnt;
    rxcrc_nxt = (accept && in_tail) ? {rxcrc_q[CRC_W-BYTE_W-1:0], in_byte} : rxcrc_q;
    // The strobe may share a cycle with the last byte, so judge on next values.
    frame_ok = (cnt_nxt == CNT_W'(TOTAL)) && (rxcrc_nxt == crc_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt   <= '0;
      rxcrc_q  <= '0;
      base_q   <= '0;
      err_flag <= 1'b0;
    end else begin
      rxcrc_q <= rxcrc_nxt;
      if (accept && in_hdr) base_q <= {base_q[ADDR_W-BYTE_W-1:0], in_byte};
      if (eof_acc) begin
        rx_cnt   <= '0;
        err_flag <= !frame_ok;
      end else begin
        rx_cnt <= cnt_nxt;
      end
    end
  end

  crcw_crc_acc u_crc (
    .clk (clk),
    .rst (rst),
    .clr (eof_acc),
    .en  (accept && (in_hdr || in_data)),
    .din (in_byte),
    .crc (crc_q)
  );

  crcw_stage_buf #(.DEPTH(BURST), .DW(BYTE_W)) u_buf (
    .clk   (clk),
    .we    (accept && in_data),
    .waddr (IDX_W'(rx_cnt - CNT_W'(HDR))),
    .wdata (in_byte),
    .raddr (rd_idx),
    .rdata (buf_rdata)
  );

  crcw_commit_seq #(.ADDR_W(ADDR_W), .BURST(BURST), .DW(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (eof_acc && frame_ok),
    .base      (base_q),
    .prot_sel  (prot_sel),
    .rdata     (buf_rdata),
    .rd_idx    (rd_idx),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/crcw_checker.sv
module crcw_checker #(
  parameter int ADDR_W = 16,
  parameter int BURST  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_eof,
  input logic [1:0]        prot_sel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              err_flag,
  input logic              busy
);

  localparam int WC_W = $clog2(BURST + 2) + 1;
  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst)                 wcnt <= '0;
    else if (in_eof && !busy) wcnt <= '0;
    else if (mem_we && wcnt != '1) wcnt <= wcnt + 1'b1;
  end

  function automatic logic guarded(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    return (s == 2'd3) || (s == 2'd2 && a[ADDR_W-1]) ||
           (s == 2'd1 && a[ADDR_W-1] && a[ADDR_W-2]);
  endfunction

  AST_WRITE_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    wcnt <= WC_W'(BURST)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1); // R5

  AST_ERR_ONLY_AFTER_EOF: assert property (@(posedge clk) disable iff (rst)
    !$past(in_eof) |-> $stable(err_flag)); // R6

  AST_NO_GUARDED_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !guarded(mem_addr, $past(prot_sel))); // R7

endmodule

bind crc_burst_writer crcw_checker #(.ADDR_W(ADDR_W), .BURST(BURST)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_eof   (in_eof),
  .prot_sel (prot_sel),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .err_flag (err_flag),
  .busy     (busy)
);

// File: tb/tb_crc_burst_writer.sv
module tb_crc_burst_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 64;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [1:0]  prot_sel = '0;
  logic        mem_we, err_flag;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  crc_burst_writer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_eof(in_eof),
    .prot_sel(prot_sel), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0, nlog = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];
  int          log_t [256];
  logic [7:0]  fb [80];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (mem_we && nlog < 256) begin
      log_a[nlog] = mem_addr; log_d[nlog] = mem_wdata; log_t[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    logic msb;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int j = 7; j >= 0; j--) begin
        msb = c[15] ^ fb[i][j];
        c = c << 1;
        if (msb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 53 + k * 7 + k * k) ^ (seed << 3));
  endfunction

  function automatic bit ref_prot(input logic [15:0] a, input logic [1:0] s);
    case (s)
      2'd0: return 1'b0;
      2'd1: return a[15] & a[14];
      2'd2: return a[15];
      default: return 1'b1;
    endcase
  endfunction

  task automatic build(input logic [15:0] a, input int seed);
    logic [15:0] c;
    fb[0] = a[15:8]; fb[1] = a[7:0];
    for (int k = 0; k < NB; k++) fb[2 + k] = pat(seed, k);
    c = ref_crc(66);
    fb[66] = c[15:8]; fb[67] = c[7:0];
    for (int i = 68; i < 80; i++) fb[i] = 8'(8'hA5 ^ i);
  endtask

  task automatic send(input int nbytes, input int corrupt, input bit eof_same, input bit do_eof);
    if (corrupt >= 0) fb[corrupt] = fb[corrupt] ^ 8'h10;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = fb[i];
      in_eof = do_eof && eof_same && (i == nbytes - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof = do_eof && !(eof_same && nbytes > 0);
    @(negedge clk);
    in_eof = 1'b0;
    if (corrupt >= 0) fb[corrupt] = fb[corrupt] ^ 8'h10;
  endtask

  task automatic expect_frame(input logic [15:0] a, input int seed, input logic [1:0] p,
                              input bit good, input string req);
    int ne, bad, gaps;
    logic [15:0] ad;
    repeat (80) @(negedge clk);
    ne = 0; bad = 0; gaps = 0;
    for (int k = 0; k < NB; k++) begin
      ad = a + 16'(k);
      if (good && !ref_prot(ad, p)) begin
        if (ne < nlog) begin
          if (log_a[ne] != ad || log_d[ne] != pat(seed, k)) bad++;
        end
        ne++;
      end
    end
    for (int i = 1; i < nlog; i++) if (log_t[i] != log_t[i-1] + 1) gaps++;
    check(nlog == ne, req, "write count", nlog, ne);
    check(bad == 0, req, "address/data mismatches", bad, 0);
    if (good && p == 2'd0) check(gaps == 0, "R5", "non-consecutive writes", gaps, 0);
    check(err_flag == !good, req, "err_flag", int'(err_flag), int'(!good));
  endtask

  initial begin
    int cidx [7] = '{0, 1, 2, 33, 65, 66, 67};
    int slen [7] = '{0, 1, 2, 40, 65, 66, 67};
    repeat (4) @(negedge clk);
    check(mem_we == 1'b0, "R10", "mem_we in reset", int'(mem_we), 0);
    check(err_flag == 1'b0, "R10", "err_flag in reset", int'(err_flag), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1/R2/R9 address sweep, alternating strobe placement
    for (int s = 0; s < 8; s++) begin
      logic [15:0] a;
      a = 16'(s * 16'h2345 + 16'h0100);
      nlog = 0; build(a, s); send(68, -1, s[0], 1'b1);
      expect_frame(a, s, 2'd0, 1'b1, s[0] ? "R9" : "R1");
    end
    nlog = 0; build(16'hFFE0, 9); send(68, -1, 1'b0, 1'b1);
    expect_frame(16'hFFE0, 9, 2'd0, 1'b1, "R2");

    // R3 corruption in address, payload and checksum bytes
    for (int i = 0; i < 7; i++) begin
      nlog = 0; build(16'h4000, 20 + i); send(68, cidx[i], 1'b0, 1'b1);
      expect_frame(16'h4000, 20 + i, 2'd0, 1'b0, "R3");
    end
    nlog = 0; build(16'h4100, 28); send(68, -1, 1'b0, 1'b1);
    expect_frame(16'h4100, 28, 2'd0, 1'b1, "R6");

    // R4 short and long frames
    for (int i = 0; i < 7; i++) begin
      nlog = 0; build(16'h5000, 40 + i); send(slen[i], -1, i[0], 1'b1);
      expect_frame(16'h5000, 40 + i, 2'd0, 1'b0, "R4");
    end
    for (int n = 69; n <= 72; n += 3) begin
      nlog = 0; build(16'h5100, n); send(n, -1, 1'b0, 1'b1);
      expect_frame(16'h5100, n, 2'd0, 1'b0, "R4");
    end

    // R7 protection sweep across the quarter boundary at 0xC000
    for (int p = 0; p < 4; p++) begin
      prot_sel = 2'(p);
      nlog = 0; build(16'hBFE0, 50 + p); send(68, -1, 1'b0, 1'b1);
      expect_frame(16'hBFE0, 50 + p, 2'(p), 1'b1, "R7");
    end
    prot_sel = 2'd0;

    // R8 traffic during replay is ignored
    nlog = 0; build(16'h2000, 30); send(68, -1, 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'h5A;
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b1;
    @(negedge clk); in_eof = 1'b0;
    expect_frame(16'h2000, 30, 2'd0, 1'b1, "R8");
    nlog = 0; build(16'h2100, 31); send(68, -1, 1'b1, 1'b1);
    expect_frame(16'h2100, 31, 2'd0, 1'b1, "R8");

    // R10 reset clears err_flag and a partial frame
    nlog = 0; build(16'h3000, 60); send(20, -1, 1'b0, 1'b1);
    expect_frame(16'h3000, 60, 2'd0, 1'b0, "R4");
    build(16'h3000, 61); send(30, -1, 1'b0, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(err_flag == 1'b0, "R10", "err_flag after reset", int'(err_flag), 0);
    rst = 1'b0;
    nlog = 0; build(16'h3000, 62); send(68, -1, 1'b0, 1'b1);
    expect_frame(16'h3000, 62, 2'd0, 1'b1, "R10");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule